// File: doc/BRIEF.md
# Control-register serial slave for a differential clock buffer

This block holds the control bytes of a clock fanout buffer and gives a system-bus host access to them over a two-wire serial bus. The host uses the bus's clock and data lines. Both lines are oversampled by the chip's faster system clock. The slave answers only its own fixed 7-bit device address. It accepts a command byte and then either takes in a block of register bytes or, after a repeated start, sends them back. The slave drives the data line only to pull it low. The open-drain pad is outside the block, so the slave gives a "pull low" request to that pad.

Command 00h selects block access. In a block write, the first byte after the command is a byte count, and the register bytes follow it. In a block read, the host writes the command and then issues a repeated start with the read bit set. The slave first returns the number of registers and then the registers in ascending index order. It goes on until the host answers a byte with a not-acknowledge. The register bytes leave the block as one flat vector. Their bits feed the output stop enables, the three-state modes, the divide select and the bandwidth select of the buffer.

Top module: `ckbuf_smb_slave`

## Requirements
- R1: After reset every control byte equals RST_BYTE (00h by default) and `sda_drive_low` is 0.
- R2: An address byte whose upper seven bits equal DEV_ADDR (1101110, so DCh for write and DDh for read) is acknowledged. Any other address is not acknowledged, and the slave writes nothing and never pulls SDA low until the next start or stop.
- R3: The byte after a write address is the command and is always acknowledged. Command 00h selects block mode. The selected mode is kept across transactions until another command is written.
- R4: In block mode, the first written byte after the command is a byte count. It is acknowledged and not stored. The following bytes go to registers 0, 1, 2 and so on, each acknowledged. Bytes past the last register are acknowledged and discarded.
- R5: In a read in block mode, the first byte returned is NUM_REGS. It is followed by register 0, register 1 and so on. Past the last register the slave returns FFh.
- R6: With a nonzero command in force, written data bytes are neither acknowledged nor stored, and read bytes are FFh.
- R7: When the host answers a read byte with a not-acknowledge, the slave releases SDA and sends nothing more until a start or stop.
- R8: A start or stop seen in any state ends the transfer in progress. A partly received byte is dropped, and SDA is released. The next address match restarts the byte pointer at the count byte.
- R9: Bits travel most significant bit first. The slave begins pulling SDA low only while SCL is low.
- R10: A control byte changes only as a result of an acknowledged data byte of a block write. Register i sits at `ctrl_bytes[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 asks the pad to pull the data line low |
| ctrl_bytes | output | 8*NUM_REGS | Control registers, register i in byte lane i |

## Verification
The checks assume a clean bus. SDA changes only while SCL is low, except when the host makes a start or stop on purpose. Each SCL low phase also lasts longer than the synchroniser and edge-detect latency. This lets the slave's own SDA changes settle before SCL rises again. The host model in the bench moves in quarter-bit steps of eight system clocks. It changes the data line only a quarter bit after SCL falls, and it samples in the middle of the high phase. This keeps every transition well inside those bounds, including the starts and stops that abort a transfer in the middle.

// File: rtl/ckbuf_smb_pkg.sv
package ckbuf_smb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_IGNORE
   } smb_state_e;

   typedef enum logic [1:0] {
      ROLE_ADDR,
      ROLE_CMD,
      ROLE_WDATA
   } smb_role_e;

   localparam logic [7:0] BLOCK_CMD = 8'h00;
   localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int LINES  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_in,
   output logic [LINES-1:0] level,
   output logic [LINES-1:0] rise,
   output logic [LINES-1:0] fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("smb_line_sync: STAGES must be at least 2");
   end

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= {chain_q[STAGES-1:0], line_in[l]};
      end

      assign level[l] = chain_q[STAGES-1];
      assign rise[l]  = chain_q[STAGES-1] & ~chain_q[STAGES];
      assign fall[l]  = ~chain_q[STAGES-1] & chain_q[STAGES];
   end

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
   parameter int         NUM_REGS = 4,
   parameter int         IDX_W    = 3,
   parameter logic [7:0] RST_BYTE = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] regs_flat
);
   import ckbuf_smb_pkg::*;

   logic [7:0] regs_q [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[i] <= RST_BYTE;
         else if (wr_en && wr_idx == IDX_W'(i))
            regs_q[i] <= wr_data;
      end
      assign regs_flat[8*i +: 8] = regs_q[i];
   end

   always_comb begin
      rd_data = FILL_BYTE;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = regs_q[i];
      end
   end

endmodule

// File: rtl/smb_frame_fsm.sv
module smb_frame_fsm #(
   parameter int         NUM_REGS = 4,
   parameter int         IDX_W    = 3,
   parameter logic [6:0] DEV_ADDR = 7'b1101110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_lvl,
   input  logic             start_evt,
   input  logic             stop_evt,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             sda_drive_low
);
   import ckbuf_smb_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS);

   smb_state_e       state_q;
   smb_role_e        role_q;
   logic [3:0]       bitcnt_q;
   logic [7:0]       shift_q;
   logic [7:0]       tx_q;
   logic             rw_q;
   logic             blk_q;
   logic             cnt_phase_q;
   logic [IDX_W-1:0] idx_q;
   logic             mack_q;
   logic             drive_q;
   logic             wr_en_q;
   logic [IDX_W-1:0] wr_idx_q;
   logic [7:0]       wr_data_q;
   logic [7:0]       tx_sel;

   // byte offered for transmission at the current pointer
   always_comb begin
      if (!blk_q)           tx_sel = FILL_BYTE;
      else if (cnt_phase_q) tx_sel = 8'(NUM_REGS);
      else                  tx_sel = rd_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         role_q      <= ROLE_ADDR;
         bitcnt_q    <= '0;
         shift_q     <= '0;
         tx_q        <= '0;
         rw_q        <= 1'b0;
         blk_q       <= 1'b1;
         cnt_phase_q <= 1'b1;
         idx_q       <= '0;
         mack_q      <= 1'b0;
         drive_q     <= 1'b0;
         wr_en_q     <= 1'b0;
         wr_idx_q    <= '0;
         wr_data_q   <= '0;
      end else begin
         wr_en_q <= 1'b0;
         if (start_evt) begin
            state_q  <= ST_RX;
            role_q   <= ROLE_ADDR;
            bitcnt_q <= '0;
            drive_q  <= 1'b0;
         end else if (stop_evt) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            drive_q  <= 1'b0;
         end else begin
            unique case (state_q)
               ST_RX: begin
                  if (scl_rise && bitcnt_q != 4'd8) begin
                     shift_q  <= {shift_q[6:0], sda_lvl};
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end else if (scl_fall && bitcnt_q == 4'd8) begin
                     bitcnt_q <= '0;
                     unique case (role_q)
                        ROLE_ADDR: begin
                           if (shift_q[7:1] == DEV_ADDR) begin
                              drive_q     <= 1'b1;
                              state_q     <= ST_RX_ACK;
                              rw_q        <= shift_q[0];
                              cnt_phase_q <= 1'b1;
                              idx_q       <= '0;
                              role_q      <= ROLE_CMD;
                           end else begin
                              state_q <= ST_IGNORE;
                           end
                        end
                        ROLE_CMD: begin
                           blk_q       <= (shift_q == BLOCK_CMD);
                           drive_q     <= 1'b1;
                           state_q     <= ST_RX_ACK;
                           role_q      <= ROLE_WDATA;
                           cnt_phase_q <= 1'b1;
                           idx_q       <= '0;
                        end
                        default: begin
                           if (!blk_q) begin
                              state_q <= ST_IGNORE;
                           end else begin
                              drive_q <= 1'b1;
                              state_q <= ST_RX_ACK;
                              if (cnt_phase_q) begin
                                 cnt_phase_q <= 1'b0;
                              end else if (idx_q != LAST_IDX) begin
                                 wr_en_q   <= 1'b1;
                                 wr_idx_q  <= idx_q;
                                 wr_data_q <= shift_q;
                                 idx_q     <= idx_q + 1'b1;
                              end
                           end
                        end
                     endcase
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     if (role_q == ROLE_CMD && rw_q) begin
                        tx_q     <= tx_sel;
                        drive_q  <= ~tx_sel[7];
                        bitcnt_q <= '0;
                        state_q  <= ST_TX;
                        if (cnt_phase_q)            cnt_phase_q <= 1'b0;
                        else if (idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
                     end else begin
                        drive_q <= 1'b0;
                        state_q <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt_q == 4'd7) begin
                        drive_q <= 1'b0;
                        state_q <= ST_TX_ACK;
                     end else begin
                        bitcnt_q <= bitcnt_q + 4'd1;
                        tx_q     <= {tx_q[6:0], 1'b0};
                        drive_q  <= ~tx_q[6];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx_q     <= tx_sel;
                        drive_q  <= ~tx_sel[7];
                        bitcnt_q <= '0;
                        state_q  <= ST_TX;
                        if (cnt_phase_q)            cnt_phase_q <= 1'b0;
                        else if (idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
                     end else begin
                        state_q <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_idx        = idx_q;
   assign wr_en         = wr_en_q;
   assign wr_idx        = wr_idx_q;
   assign wr_data       = wr_data_q;
   assign sda_drive_low = drive_q;

endmodule

// File: rtl/ckbuf_smb_slave.sv
module ckbuf_smb_slave #(
   parameter int         NUM_REGS    = 4,
   parameter logic [6:0] DEV_ADDR    = 7'b1101110,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] RST_BYTE    = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  sda_drive_low,
   output logic [NUM_REGS*8-1:0] ctrl_bytes
);

   localparam int IDX_W = $clog2(NUM_REGS + 1);

   if (NUM_REGS < 1 || NUM_REGS > 254) begin : g_bad_regs
      $error("ckbuf_smb_slave: NUM_REGS must lie in 1..254");
   end

   logic [1:0]       lvl, rise, fall;
   logic             start_evt, stop_evt;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [7:0]       wr_data, rd_data;

   // lane 0 carries the clock line, lane 1 the data line
   smb_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in ({sda_in, scl_in}),
      .level   (lvl),
      .rise    (rise),
      .fall    (fall)
   );

   assign start_evt = lvl[0] & fall[1];
   assign stop_evt  = lvl[0] & rise[1];

   smb_frame_fsm #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_rise      (rise[0]),
      .scl_fall      (fall[0]),
      .sda_lvl       (lvl[1]),
      .start_evt     (start_evt),
      .stop_evt      (stop_evt),
      .rd_data       (rd_data),
      .rd_idx        (rd_idx),
      .wr_en         (wr_en),
      .wr_idx        (wr_idx),
      .wr_data       (wr_data),
      .sda_drive_low (sda_drive_low)
   );

   smb_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RST_BYTE(RST_BYTE)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .regs_flat (ctrl_bytes)
   );

endmodule

// File: rtl/ckbuf_smb_chk.sv
module ckbuf_smb_chk #(
   parameter int NUM_REGS = 4,
   parameter int IDX_W    = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_in,
   input logic                  sda_drive_low,
   input logic                  start_evt,
   input logic                  stop_evt,
   input logic                  wr_en,
   input logic [IDX_W-1:0]      wr_idx,
   input logic [NUM_REGS*8-1:0] ctrl_bytes
);

   assert_pull_on_low_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> !scl_in)
      else $error("pull-low began while SCL high");

   assert_abort_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt || stop_evt) |=> !sda_drive_low)
      else $error("SDA still pulled after start/stop");

   assert_write_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx < IDX_W'(NUM_REGS)))
      else $error("write index past last register");

   assert_change_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_bytes) |-> $past(wr_en))
      else $error("control byte changed without a write");

endmodule

bind ckbuf_smb_slave ckbuf_smb_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_in        (scl_in),
   .sda_drive_low (sda_drive_low),
   .start_evt     (start_evt),
   .stop_evt      (stop_evt),
   .wr_en         (wr_en),
   .wr_idx        (wr_idx),
   .ctrl_bytes    (ctrl_bytes)
);

// File: tb/sim_ckbuf_smb_slave.sv
`timescale 1ns/1ps
module sim_ckbuf_smb_slave;
   localparam int N = 4;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_drive_low;
   logic [N*8-1:0] ctrl_bytes;
   wire  sda_line = m_sda & ~sda_drive_low;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] exp_val_q[$];
   string      exp_req_q[$];
   logic [7:0] obs_q[$];

   always #2.5 clk = ~clk;

   ckbuf_smb_slave #(.NUM_REGS(N)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_in        (m_scl),
      .sda_in        (sda_line),
      .sda_drive_low (sda_drive_low),
      .ctrl_bytes    (ctrl_bytes)
   );

   task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops observed bus results and compares with the expectations
   initial begin
      forever begin
         @(negedge clk);
         while (obs_q.size() > 0 && exp_val_q.size() > 0) begin
            logic [7:0] o, e;
            string r;
            o = obs_q.pop_front();
            e = exp_val_q.pop_front();
            r = exp_req_q.pop_front();
            check_eq({24'h0, o}, {24'h0, e}, r);
         end
      end
   end

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wait_q();
      m_scl = 1'b1; wait_q();
      m_sda = 1'b0; wait_q();
      m_scl = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_q();
      m_scl = 1'b1; wait_q();
      m_sda = 1'b1; wait_q();
   endtask

   task automatic bus_bit(input logic b, output logic seen);
      m_sda = b;    wait_q();
      m_scl = 1'b1; wait_q();
      seen  = sda_line; wait_q();
      m_scl = 1'b0; wait_q();
   endtask

   // send a byte; expected acknowledge bit value 0 = ack, 1 = nack
   task automatic send_byte(input logic [7:0] b, input logic exp_nack, input string req);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      exp_val_q.push_back({7'b0, exp_nack});
      exp_req_q.push_back(req);
      bus_bit(1'b1, s);
      obs_q.push_back({7'b0, s});
   endtask

   task automatic recv_byte(input logic ack, input logic [7:0] exp, input string req);
      logic [7:0] b;
      logic s;
      exp_val_q.push_back(exp);
      exp_req_q.push_back(req);
      for (int i = 0; i < 8; i++) begin
         bus_bit(1'b1, s);
         b = {b[6:0], s};
      end
      obs_q.push_back(b);
      bus_bit(~ack, s);
   endtask

   task automatic check_regs(input logic [N*8-1:0] exp, input string req);
      @(negedge clk);
      check_eq(ctrl_bytes, exp, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic s;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state
      check_eq(ctrl_bytes, 32'h0, "R1");
      check_eq({31'h0, sda_drive_low}, 32'h0, "R1");

      // R4 block write: count then registers 0..3
      bus_start();
      send_byte(8'hDC, 1'b0, "R2");
      send_byte(8'h00, 1'b0, "R3");
      send_byte(8'h04, 1'b0, "R4");
      send_byte(8'hA5, 1'b0, "R4");
      send_byte(8'h3C, 1'b0, "R4");
      send_byte(8'h0F, 1'b0, "R4");
      send_byte(8'h81, 1'b0, "R4");
      bus_stop();
      check_regs(32'h810F3CA5, "R4");

      // R5 block read with repeated start, MSB first (R9), FFh past end
      bus_start();
      send_byte(8'hDC, 1'b0, "R2");
      send_byte(8'h00, 1'b0, "R3");
      bus_start();
      send_byte(8'hDD, 1'b0, "R2");
      recv_byte(1'b1, 8'h04, "R5");
      recv_byte(1'b1, 8'hA5, "R9");
      recv_byte(1'b1, 8'h3C, "R5");
      recv_byte(1'b1, 8'h0F, "R5");
      recv_byte(1'b1, 8'h81, "R5");
      recv_byte(1'b0, 8'hFF, "R5");
      bus_stop();

      // R2 foreign address: not acknowledged, rest ignored
      bus_start();
      send_byte(8'hB8, 1'b1, "R2");
      send_byte(8'h00, 1'b1, "R2");
      send_byte(8'h04, 1'b1, "R2");
      send_byte(8'h55, 1'b1, "R2");
      bus_stop();
      check_regs(32'h810F3CA5, "R2");
      bus_start();
      send_byte(8'hBB, 1'b1, "R2");
      recv_byte(1'b0, 8'hFF, "R2");
      bus_stop();

      // R4 overflow: extra bytes acknowledged and dropped
      bus_start();
      send_byte(8'hDC, 1'b0, "R2");
      send_byte(8'h00, 1'b0, "R3");
      send_byte(8'h06, 1'b0, "R4");
      send_byte(8'h11, 1'b0, "R4");
      send_byte(8'h22, 1'b0, "R4");
      send_byte(8'h33, 1'b0, "R4");
      send_byte(8'h44, 1'b0, "R4");
      send_byte(8'h55, 1'b0, "R4");
      send_byte(8'h66, 1'b0, "R4");
      bus_stop();
      check_regs(32'h44332211, "R4");

      // R6 nonzero command
      bus_start();
      send_byte(8'hDC, 1'b0, "R2");
      send_byte(8'h05, 1'b0, "R3");
      send_byte(8'h77, 1'b1, "R6");
      bus_stop();
      check_regs(32'h44332211, "R6");
      bus_start();
      send_byte(8'hDC, 1'b0, "R2");
      send_byte(8'h05, 1'b0, "R3");
      bus_start();
      send_byte(8'hDD, 1'b0, "R2");
      recv_byte(1'b0, 8'hFF, "R6");
      bus_stop();
      // R3 mode kept across transactions
      bus_start();
      send_byte(8'hDD, 1'b0, "R2");
      recv_byte(1'b0, 8'hFF, "R3");
      bus_stop();
      bus_start();
      send_byte(8'hDC, 1'b0, "R2");
      send_byte(8'h00, 1'b0, "R3");
      bus_stop();
      bus_start();
      send_byte(8'hDD, 1'b0, "R2");
      recv_byte(1'b1, 8'h04, "R3");
      recv_byte(1'b0, 8'h11, "R3");
      bus_stop();

      // R7 host nack releases the line
      bus_start();
      send_byte(8'hDD, 1'b0, "R2");
      recv_byte(1'b0, 8'h04, "R7");
      recv_byte(1'b0, 8'hFF, "R7");
      bus_stop();

      // R8 repeated start in the middle of a write restarts the pointer
      bus_start();
      send_byte(8'hDC, 1'b0, "R2");
      send_byte(8'h00, 1'b0, "R3");
      send_byte(8'h04, 1'b0, "R4");
      send_byte(8'h99, 1'b0, "R4");
      bus_start();
      send_byte(8'hDD, 1'b0, "R2");
      recv_byte(1'b1, 8'h04, "R8");
      recv_byte(1'b1, 8'h99, "R8");
      recv_byte(1'b0, 8'h22, "R8");
      bus_stop();

      // R8 stop inside a byte drops it
      bus_start();
      send_byte(8'hDC, 1'b0, "R2");
      send_byte(8'h00, 1'b0, "R3");
      send_byte(8'h04, 1'b0, "R4");
      for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
      bus_stop();
      check_regs(32'h44332299, "R8");
      check_eq({31'h0, sda_drive_low}, 32'h0, "R8");
      bus_start();
      send_byte(8'hDC, 1'b0, "R2");
      send_byte(8'h00, 1'b0, "R3");
      send_byte(8'h01, 1'b0, "R4");
      send_byte(8'h5A, 1'b0, "R8");
      bus_stop();
      check_regs(32'h4433225A, "R10");

      repeat (20) @(negedge clk);
      check_eq(exp_val_q.size(), 0, "scoreboard");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule